// File: doc/BRIEF.md
# Segment Address Translator with Ring Brackets

This block turns a virtual address into a physical address using a small bank of segment descriptor registers held on chip. Each descriptor covers a window of the virtual space given by a virtual base and a length, relocates it to a physical base, and carries two signed privilege limits: one for reads and one for writes. A lookup presents a virtual address, a read/write flag and the current ring number. One clock later the block returns the physical address, a hit flag, an access-violation flag and a translation-fault flag.

Descriptors are loaded through a configuration write port. That port accepts writes only while the mode input says the processor is in system mode. A write attempted from user mode is dropped and raises a one-cycle illegal-operation pulse. A compatibility mode bypasses the descriptor bank and uses a single base/limit pair that relocates every address below the limit.

Top module: `seg_xlate`

## Requirements
- R1: After reset every descriptor has length zero, the base/limit pair is zero and rsp_valid is 0, so the first lookup after reset returns a translation fault.
- R2: For a lookup that hits, rsp_paddr equals physical base + (vaddr - virtual base), modulo 2^32. The result appears on the clock edge that follows the cycle in which lk_valid was sampled.
- R3: A descriptor matches when virtual base <= vaddr and (vaddr - virtual base) < length, with both comparisons unsigned. A descriptor whose length is zero matches nothing.
- R4: A read (lk_write=0) that hits is allowed only when 0 <= ring <= read bracket, with both values taken as signed 8-bit. Otherwise rsp_viol=1, rsp_hit=1 and rsp_paddr=0.
- R5: A write (lk_write=1) that hits is allowed only when 0 <= ring <= write bracket, with both values signed 8-bit. Otherwise rsp_viol=1, rsp_hit=1 and rsp_paddr=0.
- R6: A negative read bracket blocks every read from that segment, whatever the ring. A negative write bracket blocks every write in the same way.
- R7: An address that matches no descriptor gives rsp_fault=1, rsp_hit=0, rsp_viol=0 and rsp_paddr=0.
- R8: When several descriptors match, the one with the lowest index supplies the translation and the brackets.
- R9: A configuration write with cfg_sys=0 changes no register, and cfg_illegal is 1 in the following cycle. A write with cfg_sys=1 loads descriptor cfg_idx, or loads the base/limit pair when cfg_legacy=1 (base from cfg_pbase, limit from cfg_len).
- R10: With legacy_mode=1 the descriptor bank is ignored. An address below the limit hits with paddr = base + vaddr and no bracket check. Any other address faults.
- R11: rsp_valid is lk_valid delayed by one cycle. When rsp_valid=0, the hit, violation and fault flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sys | input | 1 | 1 = system mode, write permitted |
| cfg_legacy | input | 1 | 1 = write targets the base/limit pair |
| cfg_idx | input | 2 | Descriptor index to write |
| cfg_vbase | input | 32 | Virtual base for the descriptor |
| cfg_len | input | 32 | Segment length (or limit) |
| cfg_pbase | input | 32 | Physical base (or legacy base) |
| cfg_rb | input | 8 | Signed read bracket |
| cfg_wb | input | 8 | Signed write bracket |
| legacy_mode | input | 1 | Selects base/limit translation |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_ring | input | 8 | Signed current ring number |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address (0 unless allowed hit) |
| rsp_hit | output | 1 | A segment matched |
| rsp_viol | output | 1 | Bracket violation |
| rsp_fault | output | 1 | No segment matched |
| cfg_illegal | output | 1 | User-mode configuration attempt |

## Verification
Lookups are aimed at the first and last word of a segment and at the word just past its end, which separates correct bounds arithmetic from an off-by-one. A segment that ends exactly at the top of the address space tests the comparison against a sum that wraps. An address inside two overlapping windows shows whether the lower index takes priority. Rings are chosen on each side of each bracket, including ring -1 and a segment with bracket -1, to tell a signed comparison from an unsigned one. Directed sequences cover a user-mode write followed by a lookup that would succeed only if the write had landed, a lookup with an empty descriptor, and legacy mode on an address that the descriptor bank would otherwise translate.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  parameter int SX_AW = 32;
  parameter int SX_BW = 8;

  typedef struct packed {
    logic [SX_AW-1:0] vbase;
    logic [SX_AW-1:0] len;
    logic [SX_AW-1:0] pbase;
    logic [SX_BW-1:0] rb;
    logic [SX_BW-1:0] wb;
  } seg_desc_t;

  // window test: the offset is formed first, so vbase+len never wraps
  function automatic logic seg_in_range(input logic [SX_AW-1:0] addr,
                                        input logic [SX_AW-1:0] vbase,
                                        input logic [SX_AW-1:0] len);
    logic [SX_AW-1:0] off;
    off = addr - vbase;
    return (addr >= vbase) && (off < len);
  endfunction

  function automatic logic [SX_AW-1:0] seg_reloc(input logic [SX_AW-1:0] addr,
                                                 input logic [SX_AW-1:0] vbase,
                                                 input logic [SX_AW-1:0] pbase);
    return pbase + (addr - vbase);
  endfunction

  // signed ring against signed bracket; a negative bracket never passes
  function automatic logic seg_bracket_ok(input logic signed [SX_BW-1:0] ring,
                                          input logic signed [SX_BW-1:0] br);
    return (ring >= 0) && (ring <= br);
  endfunction
endpackage

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
  import seg_xlate_pkg::*;
#(
  parameter int NSEG = 4,
  localparam int IW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_sys,
  input  logic                   cfg_legacy,
  input  logic [IW-1:0]          cfg_idx,
  input  seg_desc_t              cfg_desc,
  output seg_desc_t [NSEG-1:0]   desc_q,
  output logic [SX_AW-1:0]       leg_base,
  output logic [SX_AW-1:0]       leg_limit,
  output logic                   cfg_illegal
);
  logic wr_ok;
  logic wr_reject;

  assign wr_ok     = cfg_we && cfg_sys;
  assign wr_reject = cfg_we && !cfg_sys;

  for (genvar i = 0; i < NSEG; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        desc_q[i] <= '0;
      end else if (wr_ok && !cfg_legacy && (cfg_idx == IW'(i))) begin
        desc_q[i] <= cfg_desc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leg_base    <= '0;
      leg_limit   <= '0;
      cfg_illegal <= 1'b0;
    end else begin
      cfg_illegal <= wr_reject;
      if (wr_ok && cfg_legacy) begin
        leg_base  <= cfg_desc.pbase;
        leg_limit <= cfg_desc.len;
      end
    end
  end

  // R9: a user-mode attempt leaves every register as it was
  a_r9_user_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sys) |=> ($stable(desc_q) && $stable(leg_base) && $stable(leg_limit)));

  // R9: the attempt is reported in the next cycle
  a_r9_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sys) |=> cfg_illegal);

  // R1: nothing is loaded without a write strobe
  a_r1_no_spurious_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && $past(rst_n)) |=> $stable(desc_q));
endmodule

// File: rtl/seg_match_unit.sv
module seg_match_unit
  import seg_xlate_pkg::*;
#(
  parameter int NSEG = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seg_desc_t [NSEG-1:0] descs,
  input  logic [SX_AW-1:0]     vaddr,
  output logic                 any_hit,
  output seg_desc_t            sel_desc
);
  logic [NSEG-1:0] raw_hit;
  logic [NSEG-1:0] win;

  for (genvar i = 0; i < NSEG; i++) begin : g_cmp
    assign raw_hit[i] = seg_in_range(vaddr, descs[i].vbase, descs[i].len);
  end

  // isolate lowest set bit: lowest index wins
  assign win     = raw_hit & (~raw_hit + NSEG'(1));
  assign any_hit = |raw_hit;

  always_comb begin
    sel_desc = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (win[i]) sel_desc = descs[i];
    end
  end

  // R8: at most one descriptor is selected
  a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));

  // R8: the winner is a matching entry and exists whenever any entry matches
  a_r8_winner_matches: assert property (@(posedge clk) disable iff (!rst_n)
    ((win & raw_hit) == win) && (any_hit == (win != '0)));

  // R3: an empty window never matches
  for (genvar i = 0; i < NSEG; i++) begin : g_chk
    a_r3_empty_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      (descs[i].len == '0) |-> !raw_hit[i]);
  end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legacy_mode,
  input  logic [SX_AW-1:0] leg_base,
  input  logic [SX_AW-1:0] leg_limit,
  input  logic             seg_hit,
  input  seg_desc_t        sel_desc,
  input  logic [SX_AW-1:0] vaddr,
  input  logic             is_write,
  input  logic [SX_BW-1:0] ring,
  output logic             acc_hit,
  output logic             acc_viol,
  output logic             acc_fault,
  output logic [SX_AW-1:0] acc_paddr
);
  logic             leg_hit;
  logic [SX_BW-1:0] bracket;
  logic             allowed;
  logic [SX_AW-1:0] seg_paddr;

  assign leg_hit   = vaddr < leg_limit;
  assign bracket   = is_write ? sel_desc.wb : sel_desc.rb;
  assign allowed   = seg_bracket_ok($signed(ring), $signed(bracket));
  assign seg_paddr = seg_reloc(vaddr, sel_desc.vbase, sel_desc.pbase);

  always_comb begin
    acc_hit   = 1'b0;
    acc_viol  = 1'b0;
    acc_fault = 1'b0;
    acc_paddr = '0;
    if (legacy_mode) begin
      acc_hit   = leg_hit;
      acc_fault = !leg_hit;
      if (leg_hit) acc_paddr = leg_base + vaddr;
    end else if (seg_hit) begin
      acc_hit  = 1'b1;
      acc_viol = !allowed;
      if (allowed) acc_paddr = seg_paddr;
    end else begin
      acc_fault = 1'b1;
    end
  end

  // R6: a negative bracket on the selected segment always yields a violation
  a_r6_negative_bracket: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy_mode && seg_hit && $signed(bracket) < 0) |-> acc_viol);

  // R10: legacy mode never reports a bracket violation
  a_r10_legacy_no_viol: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_mode |-> !acc_viol);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NSEG = 4,
  localparam int IW = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int AW = SX_AW,
  localparam int BW = SX_BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sys,
  input  logic          cfg_legacy,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_vbase,
  input  logic [AW-1:0] cfg_len,
  input  logic [AW-1:0] cfg_pbase,
  input  logic [BW-1:0] cfg_rb,
  input  logic [BW-1:0] cfg_wb,
  input  logic          legacy_mode,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_vaddr,
  input  logic          lk_write,
  input  logic [BW-1:0] lk_ring,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_hit,
  output logic          rsp_viol,
  output logic          rsp_fault,
  output logic          cfg_illegal
);
  seg_desc_t             cfg_desc;
  seg_desc_t [NSEG-1:0]  desc_q;
  seg_desc_t             sel_desc;
  logic [AW-1:0]         leg_base;
  logic [AW-1:0]         leg_limit;
  logic                  seg_hit;
  logic                  acc_hit;
  logic                  acc_viol;
  logic                  acc_fault;
  logic [AW-1:0]         acc_paddr;

  assign cfg_desc = '{vbase: cfg_vbase, len: cfg_len, pbase: cfg_pbase,
                      rb: cfg_rb, wb: cfg_wb};

  seg_desc_bank #(.NSEG(NSEG)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sys(cfg_sys),
    .cfg_legacy(cfg_legacy), .cfg_idx(cfg_idx), .cfg_desc(cfg_desc),
    .desc_q(desc_q), .leg_base(leg_base), .leg_limit(leg_limit),
    .cfg_illegal(cfg_illegal)
  );

  seg_match_unit #(.NSEG(NSEG)) u_match (
    .clk(clk), .rst_n(rst_n), .descs(desc_q), .vaddr(lk_vaddr),
    .any_hit(seg_hit), .sel_desc(sel_desc)
  );

  seg_access_check u_check (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
    .leg_base(leg_base), .leg_limit(leg_limit), .seg_hit(seg_hit),
    .sel_desc(sel_desc), .vaddr(lk_vaddr), .is_write(lk_write),
    .ring(lk_ring), .acc_hit(acc_hit), .acc_viol(acc_viol),
    .acc_fault(acc_fault), .acc_paddr(acc_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_hit   <= 1'b0;
      rsp_viol  <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_paddr <= lk_valid ? acc_paddr : '0;
      rsp_hit   <= lk_valid && acc_hit;
      rsp_viol  <= lk_valid && acc_viol;
      rsp_fault <= lk_valid && acc_fault;
    end
  end

  // R11: one-cycle response latency
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R11: flags quiet without a response
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_viol || rsp_fault));

  // R7: a fault excludes hit and violation and carries no address
  a_r7_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (!rsp_hit && !rsp_viol && rsp_paddr == '0));

  // R4: a violation belongs to a hit and carries no address
  a_r4_viol_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_viol |-> (rsp_hit && rsp_paddr == '0));
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sys = 1'b0, cfg_legacy = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_vbase = '0, cfg_len = '0, cfg_pbase = '0;
  logic [7:0]  cfg_rb = '0, cfg_wb = '0;
  logic        legacy_mode = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_ring = '0;
  logic        rsp_valid, rsp_hit, rsp_viol, rsp_fault, cfg_illegal;
  logic [31:0] rsp_paddr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sys(cfg_sys),
    .cfg_legacy(cfg_legacy), .cfg_idx(cfg_idx), .cfg_vbase(cfg_vbase),
    .cfg_len(cfg_len), .cfg_pbase(cfg_pbase), .cfg_rb(cfg_rb), .cfg_wb(cfg_wb),
    .legacy_mode(legacy_mode), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_ring(lk_ring), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit), .rsp_viol(rsp_viol),
    .rsp_fault(rsp_fault), .cfg_illegal(cfg_illegal)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] va;
    logic        wr;
    logic [7:0]  ring;
    logic        hit;
    logic        viol;
    logic        fault;
    logic [31:0] pa;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{4'd2,  32'h0000_1000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 32'h8000_0000}, // R2 first word
    '{4'd3,  32'h0000_10FF, 1'b0, 8'h03, 1'b1, 1'b0, 1'b0, 32'h8000_00FF}, // R3 last word, R4 ring==rb
    '{4'd2,  32'h0000_1100, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 32'h9000_0080}, // R2 second segment
    '{4'd8,  32'h0000_1080, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0, 32'h8000_0080}, // R8 overlap, lower index
    '{4'd5,  32'h0000_1050, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 32'h8000_0050}, // R5 ring==wb
    '{4'd5,  32'h0000_1050, 1'b1, 8'h02, 1'b1, 1'b1, 1'b0, 32'h0000_0000}, // R5 ring>wb
    '{4'd4,  32'h0000_1050, 1'b0, 8'h04, 1'b1, 1'b1, 1'b0, 32'h0000_0000}, // R4 ring>rb
    '{4'd3,  32'h0000_117F, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0, 32'h9000_00FF}, // R3 end of seg 1
    '{4'd7,  32'h0000_1180, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 32'h0000_0000}, // R7 one past end
    '{4'd3,  32'h0000_2000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 32'h0000_0000}, // R3 zero length
    '{4'd7,  32'h0000_0FFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 32'h0000_0000}, // R7 below base
    '{4'd6,  32'hFFFF_FF10, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 32'h0000_0000}, // R6 rb=-1 read
    '{4'd3,  32'hFFFF_FFFF, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 32'h0000_01FF}, // R3 top of space
    '{4'd5,  32'hFFFF_FF10, 1'b1, 8'h01, 1'b1, 1'b1, 1'b0, 32'h0000_0000}, // R5 ring>wb=0
    '{4'd4,  32'h0000_1000, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 32'h0000_0000}, // R4 ring -1
    '{4'd5,  32'h0000_1100, 1'b1, 8'h02, 1'b1, 1'b0, 1'b0, 32'h9000_0080}  // R5 seg 1 write
  };

  task automatic cfg_write(input logic sys, input logic leg, input logic [1:0] idx,
                           input logic [31:0] vb, input logic [31:0] ln,
                           input logic [31:0] pb, input logic [7:0] rb,
                           input logic [7:0] wb);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sys = sys; cfg_legacy = leg; cfg_idx = idx;
    cfg_vbase = vb; cfg_len = ln; cfg_pbase = pb; cfg_rb = rb; cfg_wb = wb;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sys = 1'b0; cfg_legacy = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic wr, input logic [7:0] ring);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_ring = ring;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic check_rsp(input string tag, input logic hit, input logic viol,
                           input logic fault, input logic [31:0] pa);
    n_run++;
    if (!(rsp_valid === 1'b1 && rsp_hit === hit && rsp_viol === viol &&
          rsp_fault === fault && rsp_paddr === pa)) begin
      n_fail++;
      $display("FAIL %s: got v=%b h=%b x=%b f=%b pa=%h, want v=1 h=%b x=%b f=%b pa=%h",
               tag, rsp_valid, rsp_hit, rsp_viol, rsp_fault, rsp_paddr,
               hit, viol, fault, pa);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic want);
    n_run++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got %b, want %b", tag, got, want);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_bit("R1 rsp_valid after reset", rsp_valid, 1'b0);
    check_bit("R1 cfg_illegal after reset", cfg_illegal, 1'b0);
    lookup(32'h0000_0000, 1'b0, 8'h00);
    check_rsp("R1 empty bank faults", 1'b0, 1'b0, 1'b1, 32'h0);

    // system-mode loads (R9)
    cfg_write(1'b1, 1'b0, 2'd0, 32'h0000_1000, 32'h100, 32'h8000_0000, 8'sd3, 8'sd1);
    cfg_write(1'b1, 1'b0, 2'd1, 32'h0000_1080, 32'h100, 32'h9000_0000, 8'sd2, 8'sd2);
    cfg_write(1'b1, 1'b0, 2'd2, 32'h0000_2000, 32'h0,   32'hA000_0000, 8'sd7, 8'sd7);
    cfg_write(1'b1, 1'b0, 2'd3, 32'hFFFF_FF00, 32'h100, 32'h0000_0100, 8'hFF, 8'sd0);

    for (int k = 0; k < 16; k++) begin
      lookup(VECS[k].va, VECS[k].wr, VECS[k].ring);
      check_rsp($sformatf("R%0d vector %0d", VECS[k].req, k),
                VECS[k].hit, VECS[k].viol, VECS[k].fault, VECS[k].pa);
    end

    // R9: user-mode write to slot 2 is dropped and flagged
    @(negedge clk);
    cfg_we = 1'b1; cfg_sys = 1'b0; cfg_idx = 2'd2;
    cfg_vbase = 32'h0000_2000; cfg_len = 32'h40; cfg_pbase = 32'hA000_0000;
    cfg_rb = 8'sd7; cfg_wb = 8'sd7;
    @(negedge clk);
    cfg_we = 1'b0;
    check_bit("R9 cfg_illegal pulse", cfg_illegal, 1'b1);
    @(negedge clk);
    check_bit("R9 cfg_illegal clears", cfg_illegal, 1'b0);
    lookup(32'h0000_2010, 1'b0, 8'h00);
    check_rsp("R9 user write ignored", 1'b0, 1'b0, 1'b1, 32'h0);

    // R9: same write in system mode lands
    cfg_write(1'b1, 1'b0, 2'd2, 32'h0000_2000, 32'h40, 32'hA000_0000, 8'sd7, 8'sd7);
    check_bit("R9 no flag in system mode", cfg_illegal, 1'b0);
    lookup(32'h0000_2010, 1'b0, 8'h00);
    check_rsp("R9 system write applied", 1'b1, 1'b0, 1'b0, 32'hA000_0010);

    // R11: idle cycle gives no response
    @(negedge clk);
    check_bit("R11 rsp_valid idle", rsp_valid, 1'b0);
    check_bit("R11 fault idle", rsp_fault, 1'b0);

    // R10: legacy base/limit
    cfg_write(1'b1, 1'b1, 2'd0, 32'h0, 32'h200, 32'h4000_0000, 8'h0, 8'h0);
    legacy_mode = 1'b1;
    lookup(32'h0000_01FF, 1'b1, 8'h05);
    check_rsp("R10 legacy below limit", 1'b1, 1'b0, 1'b0, 32'h4000_01FF);
    lookup(32'h0000_0200, 1'b0, 8'h00);
    check_rsp("R10 legacy at limit", 1'b0, 1'b0, 1'b1, 32'h0);
    lookup(32'h0000_1000, 1'b0, 8'h00);
    check_rsp("R10 bank bypassed", 1'b0, 1'b0, 1'b1, 32'h0);
    legacy_mode = 1'b0;
    lookup(32'h0000_1000, 1'b0, 8'h00);
    check_rsp("R2 bank restored", 1'b1, 1'b0, 1'b0, 32'h8000_0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule